// File: doc/BRIEF.md
# Register-Bank Write-Protection Guard

This block sits on a single-cycle register port in front of a bank of configuration registers. While protection is on, it suppresses every write that lands in the low 512-byte offset window. Such a write is never seen by the bank. Instead the guard raises a sticky violation flag and keeps the word offset of the refused write. Writes above the window always reach the bank. Reads are never held back.

The guard owns two registers of its own, both placed inside the window's address range but exempt from its protection. The control register at 0x1E4 holds the protection switch and accepts a write only when that write carries the 24-bit key. The violation register at 0x1E8 is read-only. A keyed control write sets the switch and wipes the violation record in the same cycle. Read data for the two guard registers comes from the guard; for every other address it comes from the bank's read data.

Top module: `wp_guard`

## Requirements
- R1: After reset the switch is off, the violation flag is 0, the offset field is 0, and reads of 0x1E4 and 0x1E8 return 0.
- R2: With protection off, a write to any non-guard address in 0x000..0x1FF raises `bank_we` in the same cycle, and the violation register does not change.
- R3: With protection on, a write to a non-guard address in 0x000..0x1FF leaves `bank_we` low.
- R4: A write to any address at or above 0x200 raises `bank_we`, whatever the switch setting.
- R5: A refused write sets bit 0 of the violation register from the next cycle on, and the bit stays set until a keyed control write.
- R6: A refused write loads bits 23:8 of the violation register with its address bits 8:2, zero-extended; a later refused write overwrites the value.
- R7: A write to 0x1E4 whose bits 31:8 equal 0x4D4154 loads the switch (bit 0 of the control register) from write-data bit 0 and clears the flag and the offset field. Bits 31:1 of the control register read as 0.
- R8: A write to 0x1E4 with any other value in bits 31:8 changes neither the switch nor the violation register.
- R9: Writes to 0x1E4 and 0x1E8 never raise `bank_we` and never count as violations; a write to 0x1E8 changes nothing.
- R10: `bus_rdata` is combinational from the address: the guard registers at 0x1E4 and 0x1E8, `bank_rdata` elsewhere. `bank_re` follows `bus_re` for every non-guard address, with protection on or off.
- R11: Reset is synchronous and active-low; it zeroes all guard state even while a write is being presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data |
| bank_we | output | 1 | Write strobe passed to the register bank |
| bank_re | output | 1 | Read strobe passed to the register bank |
| bank_rdata | input | 32 | Read data from the register bank |

## Verification
The bench checks the edges of the window: offsets 0x000, 0x1FC and 0x200. A guard with an off-by-one range check would either let the last word through or refuse the first free one. It writes the control register with nearly correct keys and with a correct key that turns protection off. A design that loaded the switch before testing the key, or that left the flag set after a keyed write, would show a stale switch or a stuck flag on readback. Back-to-back refused writes check that the offset field follows the latest write and does not freeze on the first. Writes to both guard registers with protection on check that neither one locks out software or reports itself as a violation.

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int ADDR_W   = 12,
  parameter int WIN_BITS = 9,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h1E4,
  parameter logic [ADDR_W-1:0] VIOL_OFS = 12'h1E8,
  parameter logic [23:0] UNLOCK_KEY = 24'h4D4154
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic              bank_we,
  output logic              bank_re,
  input  logic [31:0]       bank_rdata
);
  localparam int OFS_W = WIN_BITS - 2;

  logic             lock_on;
  logic             viol_flag;
  logic [OFS_W-1:0] viol_ofs;

  logic in_window, hit_ctrl, hit_viol, guard_reg, refused, key_match, ctrl_wr, ctrl_accept;
  logic unused_bits;

  assign in_window   = (bus_addr[ADDR_W-1:WIN_BITS] == '0);
  assign hit_ctrl    = (bus_addr == CTRL_OFS);
  assign hit_viol    = (bus_addr == VIOL_OFS);
  assign guard_reg   = hit_ctrl | hit_viol;
  assign refused     = bus_we & lock_on & in_window & ~guard_reg;
  assign key_match   = (bus_wdata[31:8] == UNLOCK_KEY);
  assign ctrl_wr     = bus_we & hit_ctrl;
  assign ctrl_accept = ctrl_wr & key_match;
  assign unused_bits = ^bus_wdata[7:1];

  assign bank_we = bus_we & ~guard_reg & ~refused;
  assign bank_re = bus_re & ~guard_reg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_on   <= 1'b0;
      viol_flag <= 1'b0;
      viol_ofs  <= '0;
    end else if (ctrl_accept) begin
      lock_on   <= bus_wdata[0];
      viol_flag <= 1'b0;
      viol_ofs  <= '0;
    end else if (refused) begin
      viol_flag <= 1'b1;
      viol_ofs  <= bus_addr[WIN_BITS-1:2];
    end
  end

  always_comb begin
    if (hit_ctrl)
      bus_rdata = {31'b0, lock_on};
    else if (hit_viol)
      bus_rdata = {8'b0, {(16-OFS_W){1'b0}}, viol_ofs, 7'b0, viol_flag};
    else
      bus_rdata = bank_rdata;
  end

  p_refused_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && lock_on && in_window && !guard_reg) |=> viol_flag);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !ctrl_accept) |=> viol_flag);

  p_offset_latest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> (bus_rdata[23:8] == 16'($past(bus_addr[WIN_BITS-1:2]))) || !hit_viol);

  p_keyed_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_accept |=> (!viol_flag && viol_ofs == '0 && lock_on == $past(bus_wdata[0])));

  p_bad_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !key_match) |=> ($stable(lock_on) && $stable(viol_flag) && $stable(viol_ofs)));

  p_above_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !in_window) |-> bank_we);

  p_guard_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    guard_reg |-> (!bank_we && !bank_re));
endmodule

// File: tb/wp_guard_tb.sv
`timescale 1ns/1ps
module wp_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata, bank_rdata = '0;
  logic        bank_we, bank_re;

  int vectors = 0, miscompares = 0;
  bit m_on = 0, m_flag = 0;
  int m_ofs = 0;
  localparam logic [23:0] KEY = 24'h4D4154;

  always #2 clk = ~clk;

  wp_guard u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .bank_we(bank_we),
    .bank_re(bank_re), .bank_rdata(bank_rdata));

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [11:0] a, input logic [31:0] d, input bit we, input bit re,
                      input bit rst, input string rtag);
    bit grd, inwin, blk, exp_we;
    logic [31:0] exp_rd;
    string wtag;
    bus_addr = a; bus_wdata = d; bus_we = we; bus_re = re; rst_n = !rst;
    bank_rdata = $urandom();
    #1;
    grd   = (a == 12'h1E4) || (a == 12'h1E8);
    inwin = (a < 12'h200);
    blk   = we && m_on && inwin && !grd;
    exp_we = we && !grd && !blk;
    if (grd) wtag = "R9"; else if (!inwin) wtag = "R4"; else if (m_on) wtag = "R3"; else wtag = "R2";
    if (a == 12'h1E4) exp_rd = {31'b0, m_on};
    else if (a == 12'h1E8) exp_rd = {8'b0, 16'(m_ofs), 7'b0, m_flag};
    else exp_rd = bank_rdata;
    if (!rst) begin
      cmp(wtag, "bank_we", {31'b0, bank_we}, {31'b0, exp_we});
      cmp("R10", "bank_re", {31'b0, bank_re}, {31'b0, re && !grd});
      cmp(rtag, "bus_rdata", bus_rdata, exp_rd);
    end
    @(posedge clk);
    if (rst) begin m_on = 0; m_flag = 0; m_ofs = 0; end
    else if (we && a == 12'h1E4 && d[31:8] == KEY) begin m_on = d[0]; m_flag = 0; m_ofs = 0; end
    else if (blk) begin m_flag = 1; m_ofs = int'(a[8:2]); end
    @(negedge clk);
    bus_we = 0; bus_re = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string t); step(a, 0, 0, 1, 0, t); endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d); step(a, d, 1, 0, 0, "R10"); endtask

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [11:0] ra;
    @(negedge clk);
    step(12'h010, 32'h1, 1, 0, 1, "R11");
    step(12'h010, 32'h1, 1, 0, 1, "R11");
    rd(12'h1E4, "R1"); rd(12'h1E8, "R1");
    wr(12'h000, 32'hAAAA); wr(12'h1FC, 32'h5); rd(12'h1E8, "R2");
    wr(12'h1E4, {24'h4D4155, 8'h01}); rd(12'h1E4, "R8");
    wr(12'h1E4, {KEY, 8'h01}); rd(12'h1E4, "R7");
    wr(12'h200, 32'h1); wr(12'hFFC, 32'h2); rd(12'h1E8, "R4");
    wr(12'h000, 32'h3); rd(12'h1E8, "R5");
    wr(12'h1FC, 32'h3); rd(12'h1E8, "R6");
    wr(12'h044, 32'h3); wr(12'h1E8, 32'hFFFFFFFF); rd(12'h1E8, "R6");
    wr(12'h1E4, {24'hB2BEAB, 8'h00}); rd(12'h1E4, "R8"); rd(12'h1E8, "R8");
    rd(12'h100, "R10"); rd(12'h300, "R10");
    wr(12'h1E4, {KEY, 8'h01}); rd(12'h1E8, "R7"); rd(12'h1E4, "R7");
    wr(12'h080, 32'h7); rd(12'h1E8, "R5");
    step(12'h080, 32'h7, 1, 0, 1, "R11"); rd(12'h1E4, "R11"); rd(12'h1E8, "R11");
    wr(12'h1E4, {KEY, 8'h01});
    wr(12'h1E4, {KEY, 8'h00}); wr(12'h004, 32'h9); rd(12'h1E8, "R2");
    for (int i = 0; i < 600; i++) begin
      case ($urandom_range(0, 5))
        0: ra = 12'h1E4;
        1: ra = 12'h1E8;
        2: ra = 12'($urandom_range(128, 1023) * 4);
        default: ra = 12'($urandom_range(0, 127) * 4);
      endcase
      if (ra == 12'h1E4 && $urandom_range(0, 1) == 1)
        step(ra, {KEY, 7'b0, 1'($urandom_range(0, 1))}, 1, 0, 0, "R7");
      else
        step(ra, $urandom(), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0, "R10");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule